// File: doc/BRIEF.md
# Read-Windowed Tweeter and Offset Detector

This block measures, for each amplifier channel, two diagnostic conditions over a window that the host bus defines instead of a timer. The window opens when either diagnostic enable goes from 0 to 1, or when the host reads. It closes at the next host read. That read latches the results of the window just ended and opens the next window in the same cycle.

In AC mode the block counts rising edges of a peak-current comparator. A select input picks either the high-current or the low-current comparator. If fewer than three edges arrive during the window, the channel reports its tweeter as open.

In offset mode the block reports excess DC offset only if the offset comparator stayed asserted on every cycle of the window. If an overload that triggers short-circuit protection appears at any point in the window, both results for that channel are voided: they read as "no fault" and a separate void flag is raised. All comparator and overload inputs are asynchronous. Each passes through a two-flop synchronizer before use.

Top module: `tw_ofs_diag`

## Requirements
- R1: After reset, all of `twt_open_o`, `ofs_fault_o` and `win_void_o` are 0.
- R2: With `thr_sel_i`=0 only `peak_hi_i` edges are counted; with `thr_sel_i`=1 only `peak_lo_i` edges are counted. The other comparator has no effect.
- R3: At a read that closes a valid window with `ac_en_i`=1, `twt_open_o` of a channel is 1 when fewer than 3 counted edges occurred in the window, and 0 when 3 or more occurred. The counter saturates at 3.
- R4: A comparator level held high for many cycles counts as a single edge.
- R5: At a read that closes a valid window with `ofs_en_i`=1, `ofs_fault_o` of a channel is 1 only if its offset comparator was 1 on every cycle of the window. A single low cycle gives 0.
- R6: If a channel's overload input is seen at any cycle of the window, including the closing read cycle, that read gives `twt_open_o`=0, `ofs_fault_o`=0 and `win_void_o`=1 for that channel.
- R7: Outputs change only at the clock edge of a read. The read returns the result of the window it closes, and comparator activity before a read is not counted in the next window.
- R8: A 0-to-1 change of `ac_en_i` or `ofs_en_i` restarts the window and discards the counts and history gathered so far.
- R9: A read with no window opened since reset gives all results 0 and `win_void_o`=1.
- R10: At a read, `twt_open_o` is 0 when `ac_en_i`=0, and `ofs_fault_o` is 0 when `ofs_en_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ac_en_i | input | 1 | AC (tweeter) diagnostic enable; a rising edge arms a window |
| ofs_en_i | input | 1 | Offset diagnostic enable; a rising edge arms a window |
| thr_sel_i | input | 1 | 0: count high-threshold comparator, 1: count low-threshold comparator |
| read_i | input | 1 | Host read strobe, one cycle; closes and reopens the window |
| peak_hi_i | input | NCH | High-threshold peak-current comparators, asynchronous |
| peak_lo_i | input | NCH | Low-threshold peak-current comparators, asynchronous |
| ofs_cmp_i | input | NCH | DC offset comparators, asynchronous |
| ovl_i | input | NCH | Short-circuit protection active, asynchronous |
| twt_open_o | output | NCH | Open tweeter result of the last closed window |
| ofs_fault_o | output | NCH | Excess offset result of the last closed window |
| win_void_o | output | NCH | Last closed window was voided or never opened |

## Verification
The main function is tried with edge counts just below, at and above three on the selected comparator. Some of these runs carry many edges on the unselected comparator, which separates correct threshold selection from counting both comparators. Offset runs use a level held across the whole window and the same level with a single-cycle dropout, which separates real persistence checking from sampling at the read alone. A held-high comparator, an enable re-arm in mid-window, and an overload pulse show that the block counts edges rather than levels, discards history on re-arm, and voids the window on overload.

// File: rtl/tw_ofs_pkg.sv
package tw_ofs_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned IN_GROUPS   = 4; // hi, lo, ofs, ovl
endpackage

// File: rtl/tw_ofs_sync.sv
module tw_ofs_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tw_ofs_chan.sv
module tw_ofs_chan #(
  parameter int unsigned MIN_PULSES = 3,
  localparam int unsigned CNT_W     = $clog2(MIN_PULSES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_i,
  input  logic lo_i,
  input  logic ofs_i,
  input  logic ovl_i,
  input  logic thr_sel_i,
  input  logic ac_en_i,
  input  logic ofs_en_i,
  input  logic read_i,
  input  logic arm_i,
  output logic twt_open_o,
  output logic ofs_fault_o,
  output logic void_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSES);

  logic             peak_s, peak_q, rise;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             ok_q, ok_nx;
  logic             ovl_q, ovl_nx;
  logic             open_q;
  logic             restart;
  logic             twt_q, ofs_q, void_q;

  assign peak_s  = thr_sel_i ? lo_i : hi_i;
  assign rise    = peak_s & ~peak_q;
  assign restart = read_i | arm_i;
  assign cnt_nx  = (rise && cnt_q != CNT_MAX) ? cnt_q + CNT_W'(1) : cnt_q;
  assign ok_nx   = ok_q & ofs_i;
  assign ovl_nx  = ovl_q | ovl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_q <= 1'b0;
      cnt_q  <= '0;
      ok_q   <= 1'b0;
      ovl_q  <= 1'b0;
      open_q <= 1'b0;
    end else begin
      peak_q <= peak_s;
      if (restart) begin
        // sample of this cycle belongs to the closing window
        cnt_q  <= '0;
        ok_q   <= 1'b1;
        ovl_q  <= 1'b0;
        open_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_nx;
        ok_q   <= ok_nx;
        ovl_q  <= ovl_nx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      twt_q  <= 1'b0;
      ofs_q  <= 1'b0;
      void_q <= 1'b0;
    end else if (read_i) begin
      void_q <= ~open_q | ovl_nx;
      twt_q  <= open_q & ~ovl_nx & ac_en_i & (cnt_nx < CNT_MAX);
      ofs_q  <= open_q & ~ovl_nx & ofs_en_i & ok_nx;
    end
  end

  assign twt_open_o  = twt_q;
  assign ofs_fault_o = ofs_q;
  assign void_o      = void_q;

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !read_i |=> ($stable(twt_q) && $stable(ofs_q) && $stable(void_q)));

  p_void_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    void_q |-> (!twt_q && !ofs_q));

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !restart) |=> cnt_q == CNT_MAX);

  p_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ofs_i && !restart) |=> !ok_q);
endmodule

// File: rtl/tw_ofs_diag.sv
module tw_ofs_diag #(
  parameter int unsigned NCH        = 4,
  parameter int unsigned MIN_PULSES = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ac_en_i,
  input  logic           ofs_en_i,
  input  logic           thr_sel_i,
  input  logic           read_i,
  input  logic [NCH-1:0] peak_hi_i,
  input  logic [NCH-1:0] peak_lo_i,
  input  logic [NCH-1:0] ofs_cmp_i,
  input  logic [NCH-1:0] ovl_i,
  output logic [NCH-1:0] twt_open_o,
  output logic [NCH-1:0] ofs_fault_o,
  output logic [NCH-1:0] win_void_o
);
  import tw_ofs_pkg::*;

  localparam int unsigned SW = IN_GROUPS * NCH;

  logic [SW-1:0]  sync_q;
  logic [NCH-1:0] hi_s, lo_s, ofs_s, ovl_s;
  logic           ac_en_q, ofs_en_q, arm;

  tw_ofs_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ovl_i, ofs_cmp_i, peak_lo_i, peak_hi_i}),
    .q_o    (sync_q)
  );

  assign {ovl_s, ofs_s, lo_s, hi_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_en_q  <= 1'b0;
      ofs_en_q <= 1'b0;
    end else begin
      ac_en_q  <= ac_en_i;
      ofs_en_q <= ofs_en_i;
    end
  end

  assign arm = (ac_en_i & ~ac_en_q) | (ofs_en_i & ~ofs_en_q);

  for (genvar c = 0; c < int'(NCH); c++) begin : g_ch
    tw_ofs_chan #(.MIN_PULSES(MIN_PULSES)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .hi_i        (hi_s[c]),
      .lo_i        (lo_s[c]),
      .ofs_i       (ofs_s[c]),
      .ovl_i       (ovl_s[c]),
      .thr_sel_i   (thr_sel_i),
      .ac_en_i     (ac_en_i),
      .ofs_en_i    (ofs_en_i),
      .read_i      (read_i),
      .arm_i       (arm),
      .twt_open_o  (twt_open_o[c]),
      .ofs_fault_o (ofs_fault_o[c]),
      .void_o      (win_void_o[c])
    );
  end

  p_ac_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && !ac_en_i) |=> twt_open_o == '0);

  p_ofs_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && !ofs_en_i) |=> ofs_fault_o == '0);
endmodule

// File: tb/tw_ofs_diag_bench.sv
module tw_ofs_diag_bench;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           ac_en = 1'b0, ofs_en = 1'b0, thr_sel = 1'b0, rd = 1'b0;
  logic [NCH-1:0] hi = '0, lo = '0, ofs = '0, ovl = '0;
  logic [NCH-1:0] twt, ofsf, vd;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  tw_ofs_diag #(.NCH(NCH), .MIN_PULSES(3)) u_tw_ofs_diag (
    .clk_i (clk), .rst_ni (rst_n), .ac_en_i (ac_en), .ofs_en_i (ofs_en),
    .thr_sel_i (thr_sel), .read_i (rd), .peak_hi_i (hi), .peak_lo_i (lo),
    .ofs_cmp_i (ofs), .ovl_i (ovl), .twt_open_o (twt), .ofs_fault_o (ofsf),
    .win_void_o (vd)
  );

  typedef struct packed {
    logic       sel;
    logic [2:0] nhi;
    logic [2:0] nlo;
    logic       lvl;
    logic       drop;
    logic       ov;
    logic       e_twt;
    logic       e_ofs;
    logic       e_void;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 3'd3, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 exactly 3, R5 persist
    '{1'b0, 3'd2, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 lo ignored, R3 two
    '{1'b1, 3'd5, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 hi ignored
    '{1'b1, 3'd0, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 lo counted
    '{1'b0, 3'd5, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 dropout, R3 saturate
    '{1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R6 overload voids
    '{1'b0, 3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 four
    '{1'b1, 3'd1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}  // R3 one, R5 persist
  };

  task automatic check(input string tag, input logic [NCH-1:0] got, input logic [NCH-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    cyc(1);
  endtask

  task automatic pulses(input int nh, input int nl);
    for (int i = 0; i < 6; i++) begin
      hi = (i < nh) ? '1 : '0;
      lo = (i < nl) ? '1 : '0;
      cyc(2);
      hi = '0; lo = '0;
      cyc(2);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    check("R1 reset twt", twt, '0);
    check("R1 reset ofs", ofsf, '0);
    check("R1 reset void", vd, '0);

    // R9: read before any window opened
    ofs = '1; pulses(0, 0); cyc(4);
    do_read();
    check("R9 no window twt", twt, '0);
    check("R9 no window ofs", ofsf, '0);
    check("R9 no window void", vd, '1);

    ac_en = 1'b1; ofs_en = 1'b1;
    for (int v = 0; v < NV; v++) begin
      thr_sel = TBL[v].sel;
      ofs = TBL[v].lvl ? '1 : '0;
      cyc(4);
      do_read(); // opens window
      pulses(int'(TBL[v].nhi), int'(TBL[v].nlo));
      if (TBL[v].drop) begin ofs = '0; cyc(1); ofs = '1; end
      if (TBL[v].ov) begin ovl = '1; cyc(1); ovl = '0; end
      cyc(4);
      do_read();
      check($sformatf("R3 vec%0d twt", v), twt, {NCH{TBL[v].e_twt}});
      check($sformatf("R5 vec%0d ofs", v), ofsf, {NCH{TBL[v].e_ofs}});
      check($sformatf("R6 vec%0d void", v), vd, {NCH{TBL[v].e_void}});
    end

    // R7: no update without read; activity before a read not carried over
    thr_sel = 1'b0; ofs = '0; cyc(4);
    do_read();
    pulses(1, 0); cyc(4);
    do_read();
    check("R7 result after 1 pulse", twt, '1);
    pulses(5, 0); cyc(4);
    check("R7 held without read", twt, '1);
    do_read();
    check("R7 new window result", twt, '0);
    do_read();
    check("R7 prior pulses not carried", twt, '1);

    // R4: held level counts once
    do_read();
    hi = '1; cyc(12); hi = '0; cyc(2);
    pulses(1, 0); cyc(4);
    do_read();
    check("R4 held high one edge", twt, '1);

    // R8: enable rise re-arms and discards counts
    do_read();
    pulses(2, 0); cyc(4);
    ac_en = 1'b0; cyc(1); ac_en = 1'b1;
    pulses(2, 0); cyc(4);
    do_read();
    check("R8 rearm discards", twt, '1);

    // R10: disabled AC mode reports no open tweeter
    ac_en = 1'b0; ofs = '1; cyc(4);
    do_read();
    cyc(6);
    do_read();
    check("R10 ac disabled", twt, '0);
    check("R10 ofs still enabled", ofsf, '1);
    ofs_en = 1'b0; cyc(2);
    do_read();
    check("R10 ofs disabled", ofsf, '0);

    // R6: overload on a single channel only
    ac_en = 1'b1; ofs_en = 1'b1; cyc(4);
    do_read();
    ovl = 4'b0100; cyc(1); ovl = '0; cyc(4);
    do_read();
    check("R6 single ch void", vd, 4'b0100);
    check("R6 single ch ofs", ofsf, 4'b1011);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule